// File: doc/BRIEF.md
# Serial Peripheral Bus Master Controller

This block is a memory-mapped master for a four-wire serial peripheral bus. Software sets up the channel through a control word: which device's chip select to drive and which serial clock rate to use. It then starts a transfer through a second word, and moves payload through a third. One transfer moves one, two, three or four bytes, most significant bit first. The transfer either sends the upper bytes of the data word or captures the incoming bytes into the upper part of the data word.

Software polls a sticky completion bit in the control word to find the end of a transfer, and clears it by writing a one to it. Writing an all-zero control word releases every chip select. The serial clock idles low. Outgoing data changes on the falling edge, and incoming data is sampled on the rising edge. The clock rate comes from the system clock frequency, which is a parameter, divided down to a power-of-two multiple of 1 MHz.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the control word (byte address 0x00), the transfer word (0x0C) and the data word (0x10) all read zero, every chip select is high and the serial clock is low.
- R2: Control bits 9:7 hold the device selection: bit 7+i drives chip select cs_n[i] low, and the written value reads back unchanged.
- R3: The clock code in control bits 6:4 gives a serial clock half-period of REF_HZ / (2 * 1 MHz * 2^c) system cycles for codes c = 0..5, with a minimum of one cycle. Codes 6 and 7 behave as code 5.
- R4: Writing the transfer word with bit 0 = 1 and type bits 3:2 = 1 sends the top 8*(n+1) bits of the data word on mosi, most significant bit first, where n is given by bits 5:4. Each bit is valid at the rising serial clock edge, and the data word keeps its value.
- R5: With type bits 3:2 = 0, the transfer samples miso on each rising serial clock edge. At the end the data word holds the received 8*(n+1) bits left-aligned, with the lower bits zero.
- R6: At the end of a transfer, control bit 3 (complete) becomes 1 and transfer bit 0 (start) becomes 0. The serial clock is then low.
- R7: Writing the control word with bit 3 = 1 clears the complete flag. Writing it with bit 3 = 0 leaves the flag as it was.
- R8: Writing zero to the control word while idle releases every chip select and clears the clock code.
- R9: While a transfer runs, writes to the transfer word and to the data word are ignored: a second start request begins no transfer, and the payload is not altered.
- R10: When no transfer runs, the serial clock stays low and does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at REF_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the devices |
| miso | input | 1 | Serial data from the devices |
| cs_n | output | 3 | Active-low chip selects, one per device |

## Verification
The bench builds the controller with REF_HZ set to 32 MHz instead of the 64 MHz default. Code 0 then gives a 16-cycle half-period, so that transfers stay short. Codes 4 and 5 both reach the one-cycle floor, and code 7 has to clamp to that same rate, so the lower limit of the divider is checked in every run. Slow rates give long transfers, which leave room to issue writes in the middle of a transfer and observe that they are ignored.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int          WORD_W    = 32;
    localparam int          DEV_W     = 3;
    localparam int          CODE_W    = 3;
    localparam int          ADDR_W    = 5;
    localparam int          NBITS_W   = 6;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] ADDR_XFER = 5'h0C;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 5'h10;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_RSV2  = 2'd2,
        KIND_RSV3  = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic [DEV_W-1:0]  dev;
        logic [CODE_W-1:0] rate;
        logic              done;
    } chan_ctrl_t;

    typedef struct packed {
        logic [1:0]  len;
        xfer_kind_e  kind;
        logic        mode;
        logic        start;
    } xfer_ctrl_t;

endpackage

// File: rtl/spi_rate_sel.sv
module spi_rate_sel #(
    parameter int REF_HZ  = 64_000_000,
    parameter int BASE_HZ = 1_000_000,
    parameter int CODES   = 6,
    parameter int CODE_W  = 3,
    parameter int CNT_W   = 6
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  half
);

    localparam int ENTRIES = 1 << CODE_W;

    logic [CNT_W-1:0] table_w [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_rate
        localparam int EFF = (g < CODES) ? g : CODES - 1;
        localparam int RAW = REF_HZ / (2 * BASE_HZ * (1 << EFF));
        localparam int VAL = (RAW < 1) ? 1 : RAW;
        assign table_w[g] = CNT_W'(VAL);
    end

    assign half = table_w[code];

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 6,
    parameter int NBITS_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               write_mode,
    input  logic [NBITS_W-1:0] nbits,
    input  logic [DATA_W-1:0]  tx_word,
    input  logic [CNT_W-1:0]   half,
    input  logic               miso,
    output logic               busy,
    output logic               sclk,
    output logic               mosi,
    output logic               finish,
    output logic [DATA_W-1:0]  rx_aligned
);

    typedef struct packed {
        logic               busy;
        logic               sclk;
        logic               wr;
        logic [CNT_W-1:0]   div;
        logic [NBITS_W-1:0] left;
        logic [NBITS_W-1:0] total;
        logic [DATA_W-1:0]  tx_sh;
        logic [DATA_W-1:0]  rx_sh;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        finish = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.sclk  = 1'b0;
                st_d.wr    = write_mode;
                st_d.div   = half - 1'b1;
                st_d.left  = nbits;
                st_d.total = nbits;
                st_d.tx_sh = tx_word;
                st_d.rx_sh = '0;
            end
        end else if (st_q.div != '0) begin
            st_d.div = st_q.div - 1'b1;
        end else begin
            st_d.div  = half - 1'b1;
            st_d.sclk = ~st_q.sclk;
            if (!st_q.sclk) begin
                st_d.rx_sh = {st_q.rx_sh[DATA_W-2:0], miso};
            end else begin
                st_d.tx_sh = st_q.tx_sh << 1;
                st_d.left  = st_q.left - 1'b1;
                if (st_q.left == NBITS_W'(1)) begin
                    st_d.busy = 1'b0;
                    finish    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = st_q.busy;
    assign sclk       = st_q.sclk;
    assign mosi       = st_q.busy & st_q.wr & st_q.tx_sh[DATA_W-1];
    assign rx_aligned = st_q.rx_sh << (DATA_W - int'(st_q.total));

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int REF_HZ  = 64_000_000,
    parameter int BASE_HZ = 1_000_000,
    parameter int CODES   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [DEV_W-1:0]  cs_n
);

    localparam int MAX_HALF = REF_HZ / (2 * BASE_HZ);
    localparam int CNT_W    = $clog2(MAX_HALF + 2);

    typedef struct packed {
        chan_ctrl_t        ctrl;
        xfer_ctrl_t        xfer;
        logic [WORD_W-1:0] data;
    } regs_t;

    regs_t rg_d, rg_q;

    logic               eng_busy;
    logic               eng_finish;
    logic               start_req;
    logic               wr_mode;
    logic [NBITS_W-1:0] req_bits;
    logic [CNT_W-1:0]   half;
    logic [WORD_W-1:0]  rx_aligned;

    spi_rate_sel #(
        .REF_HZ (REF_HZ),
        .BASE_HZ(BASE_HZ),
        .CODES  (CODES),
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W)
    ) u_rate (
        .code(rg_q.ctrl.rate),
        .half(half)
    );

    assign start_req = reg_wen && (reg_addr == ADDR_XFER) && reg_wdata[0] && !eng_busy;
    assign wr_mode   = (reg_wdata[3:2] == KIND_WRITE);
    assign req_bits  = NBITS_W'(({4'b0000, reg_wdata[5:4]} + 6'd1) << 3);

    spi_shift_engine #(
        .DATA_W (WORD_W),
        .CNT_W  (CNT_W),
        .NBITS_W(NBITS_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_req),
        .write_mode(wr_mode),
        .nbits     (req_bits),
        .tx_word   (rg_q.data),
        .half      (half),
        .miso      (miso),
        .busy      (eng_busy),
        .sclk      (sclk),
        .mosi      (mosi),
        .finish    (eng_finish),
        .rx_aligned(rx_aligned)
    );

    always_comb begin
        rg_d = rg_q;
        if (reg_wen) begin
            unique case (reg_addr)
                ADDR_CTRL: begin
                    if (!eng_busy) begin
                        rg_d.ctrl.dev  = reg_wdata[9:7];
                        rg_d.ctrl.rate = reg_wdata[6:4];
                    end
                    if (reg_wdata[3]) begin
                        rg_d.ctrl.done = 1'b0;
                    end
                end
                ADDR_XFER: begin
                    if (!eng_busy) begin
                        rg_d.xfer = xfer_ctrl_t'(reg_wdata[5:0]);
                    end
                end
                ADDR_DATA: begin
                    if (!eng_busy) begin
                        rg_d.data = reg_wdata;
                    end
                end
                default: ;
            endcase
        end
        if (eng_finish) begin
            rg_d.ctrl.done  = 1'b1;
            rg_d.xfer.start = 1'b0;
            if (rg_q.xfer.kind != KIND_WRITE) begin
                rg_d.data = rx_aligned;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = {22'd0, rg_q.ctrl.dev, rg_q.ctrl.rate, rg_q.ctrl.done, 3'd0};
            ADDR_XFER: reg_rdata = {26'd0, rg_q.xfer};
            ADDR_DATA: reg_rdata = rg_q.data;
            default:   reg_rdata = '0;
        endcase
    end

    assign cs_n = ~rg_q.ctrl.dev;

endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wen,
    input logic [4:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        sclk,
    input logic [2:0]  cs_n,
    input logic        busy,
    input logic        done,
    input logic [31:0] data
);

    a_r10_idle_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    a_r3_sclk_rise_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> busy);

    a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == 5'h00 && reg_wdata[3] && !busy) |=> !done);

    a_r8_zero_release: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == 5'h00 && reg_wdata == 32'd0 && !busy) |=> (cs_n == 3'b111));

    a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(data));

endmodule

bind spi_host_ctrl spi_host_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wen  (reg_wen),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .busy     (eng_busy),
    .done     (rg_q.ctrl.done),
    .data     (rg_q.data)
);

// File: tb/tb_spi_host_ctrl.sv
module tb_spi_host_ctrl;

    localparam int TB_REF = 32_000_000;

    typedef struct {
        int          nbits;
        logic [31:0] word;
        int          half;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, miso;
    logic [2:0]  cs_n;

    logic [31:0] slave_sh = '0;
    int          n_checks = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          cur_code = 0;
    bit          finished = 1'b0;
    exp_t        exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign miso = slave_sh[31];
    always @(negedge sclk) slave_sh <= slave_sh << 1;

    spi_host_ctrl #(.REF_HZ(TB_REF)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wen  (reg_wen),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .sclk     (sclk),
        .mosi     (mosi),
        .miso     (miso),
        .cs_n     (cs_n)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_half(input int code);
        int e = (code > 5) ? 5 : code;
        int h = TB_REF / (2 * 1_000_000 * (1 << e));
        return (h < 1) ? 1 : h;
    endfunction

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        v = '0;
        while (!v[3]) reg_read(5'h00, v);
    endtask

    task automatic set_chan(input logic [2:0] dev, input int code);
        cur_code = code;
        reg_write(5'h00, {22'd0, dev, 3'(code), 1'b1, 3'd0});
    endtask

    task automatic start_xfer(input int len, input bit wr, input logic [31:0] tx, input string tag);
        exp_t it;
        it.nbits = 8 * (len + 1);
        it.word  = wr ? (tx & ~(32'hFFFF_FFFF >> it.nbits)) : 32'd0;
        it.half  = exp_half(cur_code);
        it.tag   = tag;
        exp_q.push_back(it);
        reg_write(5'h0C, {26'd0, 2'(len), 2'(wr ? 1 : 0), 1'b0, 1'b1});
    endtask

    initial begin : monitor
        int   bits = 0;
        int   t0 = 0;
        int   t1 = 0;
        exp_t cur;
        logic [31:0] w = '0;
        forever begin
            @(posedge sclk);
            #1;
            if (bits == 0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected transfer", 32'd1, 32'd0);
                    cur.nbits = 1; cur.word = 0; cur.half = 0; cur.tag = "R9";
                end else begin
                    cur = exp_q.pop_front();
                end
                w  = '0;
                t0 = cyc;
            end
            if (bits == 1) t1 = cyc;
            w[31-bits] = mosi;
            bits++;
            if (bits == cur.nbits) begin
                check(w == cur.word, {cur.tag, " R4 mosi word"}, w, cur.word);
                if (cur.nbits > 1)
                    check((t1 - t0) == 2 * cur.half, {cur.tag, " R3 sclk period"},
                          32'(t1 - t0), 32'(2 * cur.half));
                bits = 0;
            end
        end
    end

    initial begin : watchdog
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : driver
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        reg_read(5'h00, v); check(v == 0, "R1 ctrl reset", v, 0);
        reg_read(5'h0C, v); check(v == 0, "R1 xfer reset", v, 0);
        reg_read(5'h10, v); check(v == 0, "R1 data reset", v, 0);
        check(cs_n == 3'b111 && sclk == 1'b0, "R1 pins reset", {28'd0, sclk, cs_n}, 32'h7);

        set_chan(3'b010, 3);
        reg_read(5'h00, v); check(v == 32'h0000_0130, "R2 ctrl readback", v, 32'h130);
        check(cs_n == 3'b101, "R2 cs for device 1", {29'd0, cs_n}, 32'h5);

        repeat (40) @(negedge clk);
        check(sclk == 1'b0, "R10 idle sclk", {31'd0, sclk}, 0);

        reg_write(5'h10, 32'hA5C3_0F96);
        start_xfer(3, 1'b1, 32'hA5C3_0F96, "write32");
        wait_done();
        reg_read(5'h10, v); check(v == 32'hA5C3_0F96, "R4 data kept after write", v, 32'hA5C3_0F96);
        reg_read(5'h0C, v); check(v == 32'h34, "R6 start bit cleared", v, 32'h34);
        check(sclk == 1'b0, "R6 sclk low at end", {31'd0, sclk}, 0);

        reg_write(5'h00, {22'd0, 3'b010, 3'd3, 1'b0, 3'd0});
        reg_read(5'h00, v); check(v[3] == 1'b1, "R7 zero write keeps done", v, 32'h138);
        reg_write(5'h00, {22'd0, 3'b010, 3'd3, 1'b1, 3'd0});
        reg_read(5'h00, v); check(v[3] == 1'b0, "R7 one write clears done", v, 32'h130);

        set_chan(3'b001, 5);
        check(cs_n == 3'b110, "R2 cs for device 0", {29'd0, cs_n}, 32'h6);
        slave_sh = 32'h1234_5678;
        start_xfer(3, 1'b0, 32'd0, "read32");
        wait_done();
        reg_read(5'h10, v); check(v == 32'h1234_5678, "R5 read 32 bits", v, 32'h1234_5678);

        set_chan(3'b100, 4);
        check(cs_n == 3'b011, "R2 cs for device 2", {29'd0, cs_n}, 32'h3);
        slave_sh = 32'hC3FF_FFFF;
        start_xfer(0, 1'b0, 32'd0, "read8");
        wait_done();
        reg_read(5'h10, v); check(v == 32'hC300_0000, "R5 read 8 left aligned", v, 32'hC300_0000);

        set_chan(3'b100, 2);
        slave_sh = 32'h9E5A_0000;
        start_xfer(2, 1'b0, 32'd0, "read24");
        wait_done();
        reg_read(5'h10, v); check(v == 32'h9E5A_0000, "R5 read 24 left aligned", v, 32'h9E5A_0000);

        set_chan(3'b010, 0);
        reg_write(5'h10, 32'hBEEF_1234);
        start_xfer(1, 1'b1, 32'hBEEF_1234, "write16 slow");
        wait_done();

        set_chan(3'b010, 7);
        reg_write(5'h10, 32'h6C00_0000);
        start_xfer(0, 1'b1, 32'h6C00_0000, "write8 code7");
        wait_done();

        set_chan(3'b010, 0);
        reg_write(5'h10, 32'h0F0F_A5A5);
        start_xfer(3, 1'b1, 32'h0F0F_A5A5, "write32 busy");
        repeat (30) @(negedge clk);
        reg_write(5'h10, 32'hFFFF_FFFF);
        reg_write(5'h0C, 32'h0000_0031);
        wait_done();
        reg_read(5'h10, v); check(v == 32'h0F0F_A5A5, "R9 data write ignored", v, 32'h0F0F_A5A5);
        reg_read(5'h0C, v); check(v == 32'h34, "R9 xfer write ignored", v, 32'h34);
        repeat (200) @(negedge clk);
        check(sclk == 1'b0, "R10 no second transfer", {31'd0, sclk}, 0);
        check(exp_q.size() == 0, "R9 queue drained", 32'(exp_q.size()), 0);

        reg_write(5'h00, 32'd0);
        check(cs_n == 3'b111, "R8 zero releases cs", {29'd0, cs_n}, 32'h7);
        reg_read(5'h00, v); check(v == 32'h8, "R8 rate cleared", v, 32'h8);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule